// File: doc/BRIEF.md
# Set-Associative LRU Tag Lookup Unit

This block keeps only the tags of a write-allocate, set-associative cache and answers, for each memory reference, whether it would hit or miss. A reference is a start address and a byte count. The block takes it over a valid/ready handshake and returns one result pulse. That pulse carries either a hit/miss verdict or an error flag. Each set stores its tags as an ordered list. The most recently used tag sits at position 0 and the least recently used tag sits at the last position, so replacement is true LRU. The block never stores data and has no dirty state.

A reference can run past the end of its line into the next line. In that case the block looks up and updates both sets over two cycles, and it still reports the pair as a single access. That access is a miss if either line misses. A reference whose first and last bytes map to sets that are neither equal nor neighbours is illegal. It is flagged as an error and leaves the tag store untouched.

The upstream side sees back-pressure only during the second cycle of a two-line reference. In that cycle `req_ready` is low and any request held on the inputs is not taken. In every other cycle `req_ready` is high, and a request is accepted on each rising edge where `req_valid` and `req_ready` are both high. The result side has no back-pressure. `res_valid` is a one-cycle pulse that the consumer must capture when it appears.

Top module: `lru_tag_unit`

## Requirements
- R1: The block has CACHE_BYTES / LINE_BYTES / ASSOC sets, and this count must be at least 2. The set index is address bits [log2(LINE_BYTES) +: log2(sets)]. The tag is the address shifted right by log2(LINE_BYTES) + log2(sets).
- R2: `req_ready` is high whenever no two-line reference is in progress. A single-line or illegal reference accepted on edge k gives `res_valid` high for exactly the cycle after edge k. When nothing is accepted, `res_valid` stays low.
- R3: A single-line reference reports `res_hit`=1 when its tag is present anywhere in its set, and 0 otherwise.
- R4: On a hit at position i, that tag moves to position 0 and positions 0..i-1 each shift down one place. When the tag appears more than once, the match at the lowest position counts.
- R5: On a miss, the new tag is written at position 0, every entry shifts down one place, and the tag at the last position is dropped.
- R6: A reference whose last byte (address + size - 1) falls in set (first set + 1) mod sets takes two cycles. The first set is updated with the start address's tag on the accepting edge. `req_ready` and `res_valid` are low in the following cycle, and a request held during that cycle is ignored. The second set is then updated with the tag of the last byte's address, and the result appears one cycle later.
- R7: A two-line reference reports `res_hit`=1 only if both lines hit. Otherwise it reports one miss.
- R8: A size of 0 is illegal. So is any reference whose first-byte and last-byte sets are neither equal nor adjacent. An illegal reference produces `res_valid`=1, `res_err`=1 and `res_hit`=0 one cycle after acceptance, and it changes no tag.
- R9: Reset clears every tag to zero. After reset, `req_ready` is 1, `res_valid` is 0, and a reference whose tag is 0 hits.
- R10: With ASSOC=1 (direct-mapped), every miss replaces the single tag in its set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A reference is offered |
| req_ready | output | 1 | A reference can be taken this cycle |
| req_addr | input | ADDR_W | Address of the first byte |
| req_size | input | SIZE_W | Byte count of the reference |
| res_valid | output | 1 | One-cycle result pulse |
| res_hit | output | 1 | The reference hit (valid with res_valid) |
| res_err | output | 1 | The reference was illegal (valid with res_valid) |

## Verification
A single-line or illegal reference accepted on a rising edge has its result due in the following cycle. A two-line reference has its result due one cycle later than that, with `req_ready` and `res_valid` both low in the cycle between. The bench drives every request on a falling edge. It reads outputs on the next falling edge, and also on the one after that when its own model says the reference spans two lines. Each sample is therefore taken half a cycle after the edge that produced it. The expected results come from an arithmetic model of the ordered tag lists. The same stimulus drives a 2-way instance and a direct-mapped instance, each checked against its own model.

// File: rtl/lru_pkg.sv
package lru_pkg;
  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SECOND = 1'b1
  } lru_state_e;
endpackage

// File: rtl/lru_addr_split.sv
module lru_addr_split #(
  parameter int ADDR_W     = 16,
  parameter int SIZE_W     = 6,
  parameter int LINE_BYTES = 16,
  parameter int SETS       = 8
) (
  input  logic [ADDR_W-1:0]                                    addr,
  input  logic [SIZE_W-1:0]                                    size,
  output logic [$clog2(SETS)-1:0]                              set_lo,
  output logic [$clog2(SETS)-1:0]                              set_hi,
  output logic [ADDR_W-$clog2(LINE_BYTES)-$clog2(SETS)-1:0]    tag_lo,
  output logic [ADDR_W-$clog2(LINE_BYTES)-$clog2(SETS)-1:0]    tag_hi,
  output logic                                                 spans,
  output logic                                                 illegal
);
  localparam int LINE_SH = $clog2(LINE_BYTES);
  localparam int IDX_W   = $clog2(SETS);
  localparam int TAG_W   = ADDR_W - LINE_SH - IDX_W;

  logic [ADDR_W-1:0] last_byte;
  logic [IDX_W-1:0]  set_next;

  always_comb begin
    last_byte = addr + {{(ADDR_W-SIZE_W){1'b0}}, size} - ADDR_W'(1);
    set_lo    = addr[LINE_SH +: IDX_W];
    set_hi    = last_byte[LINE_SH +: IDX_W];
    tag_lo    = addr[ADDR_W-1 -: TAG_W];
    tag_hi    = last_byte[ADDR_W-1 -: TAG_W];
    set_next  = set_lo + IDX_W'(1);
    spans     = (set_hi != set_lo);
    illegal   = (size == '0) || (spans && (set_hi != set_next));
  end
endmodule

// File: rtl/lru_set_array.sv
module lru_set_array #(
  parameter int SETS  = 8,
  parameter int ASSOC = 2,
  parameter int TAG_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(SETS)-1:0] idx,
  input  logic [TAG_W-1:0]        tag,
  input  logic                    upd,
  output logic                    hit
);
  localparam int IDX_W = $clog2(SETS);

  logic [SETS-1:0][ASSOC-1:0][TAG_W-1:0] mem;
  logic [ASSOC-1:0][TAG_W-1:0]           row, row_next;
  logic [ASSOC-1:0]                      match;
  logic [ASSOC-1:0]                      shift;

  assign row = mem[idx];

  genvar w;
  generate
    for (w = 0; w < ASSOC; w++) begin : g_way
      assign match[w] = (row[w] == tag);
      if (w == 0) begin : g_mru
        assign row_next[w] = tag;
      end else begin : g_rest
        assign row_next[w] = shift[w] ? row[w-1] : row[w];
      end
    end
  endgenerate

  // A way moves down when no earlier way matched the tag.
  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < ASSOC; i++) begin
      shift[i] = ~seen;
      seen     = seen | match[i];
    end
  end

  assign hit = |match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (upd) begin
      mem[idx] <= row_next;
    end
  end

  // R4
  mru_install_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> mem[$past(idx)][0] == $past(tag));

  // R8
  no_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(mem));

  generate
    if (ASSOC > 1) begin : g_evict_chk
      // R5
      lru_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !hit) |=> mem[$past(idx)][ASSOC-1] == $past(row[ASSOC-2]));
    end
  endgenerate
endmodule

// File: rtl/lru_ctrl.sv
module lru_ctrl
  import lru_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IDX_W-1:0] set_lo,
  input  logic [IDX_W-1:0] set_hi,
  input  logic [TAG_W-1:0] tag_lo,
  input  logic [TAG_W-1:0] tag_hi,
  input  logic             spans,
  input  logic             illegal,
  input  logic             hit,
  output logic [IDX_W-1:0] look_idx,
  output logic [TAG_W-1:0] look_tag,
  output logic             upd,
  output logic             res_valid,
  output logic             res_hit,
  output logic             res_err
);
  lru_state_e       state;
  logic [IDX_W-1:0] stash_idx;
  logic [TAG_W-1:0] stash_tag;
  logic             first_hit;
  logic             fire;

  assign req_ready = (state == ST_IDLE);
  assign fire      = req_valid && req_ready;

  always_comb begin
    if (state == ST_SECOND) begin
      look_idx = stash_idx;
      look_tag = stash_tag;
      upd      = 1'b1;
    end else begin
      look_idx = set_lo;
      look_tag = tag_lo;
      upd      = fire && !illegal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      stash_idx <= '0;
      stash_tag <= '0;
      first_hit <= 1'b0;
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_err   <= 1'b0;
    end else if (state == ST_SECOND) begin
      state     <= ST_IDLE;
      res_valid <= 1'b1;
      res_hit   <= first_hit && hit;
      res_err   <= 1'b0;
    end else begin
      res_valid <= fire && (illegal || !spans);
      res_hit   <= fire && !illegal && !spans && hit;
      res_err   <= fire && illegal;
      if (fire && !illegal && spans) begin
        state     <= ST_SECOND;
        stash_idx <= set_hi;
        stash_tag <= tag_hi;
        first_hit <= hit;
      end
    end
  end

  // R6
  two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && spans && !illegal) |=> (!req_ready && !res_valid));

  // R2
  single_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (illegal || !spans)) |=> res_valid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && state == ST_IDLE) |=> !res_valid);

  // R8
  err_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_err |-> (res_valid && !res_hit));

  // R7
  straddle_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SECOND && !hit) |=> !res_hit);
endmodule

// File: rtl/lru_tag_unit.sv
module lru_tag_unit #(
  parameter int ADDR_W      = 16,
  parameter int SIZE_W      = 6,
  parameter int CACHE_BYTES = 256,
  parameter int LINE_BYTES  = 16,
  parameter int ASSOC       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_err
);
  localparam int SETS    = CACHE_BYTES / LINE_BYTES / ASSOC;
  localparam int LINE_SH = $clog2(LINE_BYTES);
  localparam int IDX_W   = $clog2(SETS);
  localparam int TAG_W   = ADDR_W - LINE_SH - IDX_W;

  logic [IDX_W-1:0] set_lo, set_hi, look_idx;
  logic [TAG_W-1:0] tag_lo, tag_hi, look_tag;
  logic             spans, illegal, hit, upd;

  lru_addr_split #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LINE_BYTES(LINE_BYTES), .SETS(SETS)
  ) u_split (
    .addr(req_addr), .size(req_size),
    .set_lo(set_lo), .set_hi(set_hi),
    .tag_lo(tag_lo), .tag_hi(tag_hi),
    .spans(spans), .illegal(illegal)
  );

  lru_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .set_lo(set_lo), .set_hi(set_hi),
    .tag_lo(tag_lo), .tag_hi(tag_hi),
    .spans(spans), .illegal(illegal), .hit(hit),
    .look_idx(look_idx), .look_tag(look_tag), .upd(upd),
    .res_valid(res_valid), .res_hit(res_hit), .res_err(res_err)
  );

  lru_set_array #(.SETS(SETS), .ASSOC(ASSOC), .TAG_W(TAG_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .idx(look_idx), .tag(look_tag), .upd(upd), .hit(hit)
  );
endmodule

// File: tb/test_lru_tag_unit.sv
`timescale 1ns/1ps
module test_lru_tag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic [5:0]  req_size = '0;
  logic        rdy_a, rv_a, rh_a, re_a;
  logic        rdy_b, rv_b, rh_b, re_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int mt[2][16][4];

  always #2.5 clk = ~clk;

  lru_tag_unit #(.ASSOC(2)) i_lru_tag_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_a),
    .req_addr(req_addr), .req_size(req_size),
    .res_valid(rv_a), .res_hit(rh_a), .res_err(re_a));

  lru_tag_unit #(.ASSOC(1)) i_lru_tag_unit_dm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_b),
    .req_addr(req_addr), .req_size(req_size),
    .res_valid(rv_b), .res_hit(rh_b), .res_err(re_b));

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Ordered-list model: position 0 is most recently used.
  function automatic int touch(int id, int s, int ways, int t);
    int pos = -1;
    int h = 1;
    for (int i = 0; i < ways; i++)
      if (pos < 0 && mt[id][s][i] == t) pos = i;
    if (pos < 0) begin pos = ways - 1; h = 0; end
    for (int j = pos; j > 0; j--) mt[id][s][j] = mt[id][s][j-1];
    mt[id][s][0] = t;
    return h;
  endfunction

  // Returns 0 miss, 1 hit, 2 error (R1 geometry, R6 tag of last byte).
  function automatic int mref(int id, int a, int sz, output bit st);
    int sets = id ? 16 : 8;
    int ways = id ? 1 : 2;
    int tsh  = id ? 8 : 7;
    int last = (a + sz - 1) & 16'hFFFF;
    int s1 = (a >> 4) & (sets - 1);
    int s2 = (last >> 4) & (sets - 1);
    int h1, h2;
    st = 0;
    if (sz == 0) return 2;
    if (s1 == s2) return touch(id, s1, ways, a >> tsh);
    if (s2 == ((s1 + 1) % sets)) begin
      st = 1;
      h1 = touch(id, s1, ways, a >> tsh);
      h2 = touch(id, s2, ways, last >> tsh);
      return h1 & h2;
    end
    return 2;
  endfunction

  // want: -1 = model only; otherwise the hand-derived hit value for the 2-way unit
  task automatic do_ref(int a, int sz, string req, int want);
    bit st_a, st_b;
    int ea, eb;
    ea = mref(0, a, sz, st_a);
    eb = mref(1, a, sz, st_b);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a[15:0];
    req_size  = sz[5:0];
    @(negedge clk);
    if (st_a) begin
      chk(!rdy_a && !rv_a, "R6", {30'd0, rdy_a, rv_a}, 0);
      req_addr = 16'h03FF;
      req_size = 6'd3;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(rv_a == 1'b1, req, rv_a, 1);
    chk(re_a == (ea == 2), (ea == 2) ? "R8" : req, re_a, ea == 2);
    chk(rh_a == (ea == 1), st_a ? "R7" : req, rh_a, ea == 1);
    if (want >= 0) chk(rh_a == want[0], req, rh_a, want);
    chk(rv_b == 1'b1, "R10", rv_b, 1);
    chk(re_b == (eb == 2), "R10", re_b, eb == 2);
    chk(rh_b == (eb == 1), "R10", rh_b, eb == 1);
  endtask

  initial begin
    int t_seq[6] = '{1, 2, 1, 3, 1, 2};
    int h_seq[6] = '{0, 0, 1, 0, 1, 0};
    int r;
    foreach (mt[i, j, k]) mt[i][j][k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(rdy_a && rdy_b, "R9", rdy_a, 1);
    chk(!rv_a && !rv_b, "R9", rv_a, 0);
    do_ref(16'h0010, 1, "R9", 1);
    // R4 and R5: LRU ordering in set 1 of the 2-way unit
    for (int i = 0; i < 6; i++)
      do_ref((t_seq[i] << 7) | 16'h0010, 4, i == 2 || i == 4 ? "R4" : "R5", h_seq[i]);
    // R7: sets 1 and 2, first line misses, second hits; then both hit
    do_ref(16'h001E, 4, "R7", 0);
    do_ref(16'h001E, 4, "R7", 1);
    // R6: wrap from last set to set 0, second tag taken from last byte
    do_ref(16'h007F, 2, "R6", 0);
    do_ref(16'h0080, 1, "R6", 1);
    do_ref(16'h0100, 17, "R6", -1);
    // R8: illegal references, then confirm nothing changed
    do_ref(16'h0010, 0, "R8", 0);
    do_ref(16'h000F, 40, "R8", 0);
    do_ref(16'h0080, 1, "R8", 1);
    // Sweep over addresses and sizes
    r = 32'h1234_5678;
    for (int n = 0; n < 3000; n++) begin
      int a, sz;
      r  = r * 1103515245 + 12345;
      a  = (r >>> 8) & 16'h03FF;
      sz = (n % 37 == 0) ? (33 + ((r >>> 20) & 15)) : (1 + ((r >>> 18) & 15) % 20);
      if (n % 97 == 0) sz = 0;
      do_ref(a, sz, "R3", -1);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule